// File: doc/BRIEF.md
# Reloading Periodic Timer with Core Routing

This block is a free-running down-counter that advances only on a reference tick pulse, which stands for a fixed 38.4 MHz time base while the logic runs on a faster system clock. One control word holds the reload count, a timer enable, an interrupt enable and a sticky expiry flag. Each time the count runs out, the flag is set and the counter starts the next period from the reload count with no gap.

A write-only acknowledge register clears the flag and can restart the running period from the reload count. A small routing register steers the resulting request to one of four cores, as either a normal or a fast interrupt line. Software reaches all three registers over a simple single-cycle register bus. Reads are combinational on the address and have no side effects.

Top module: `ltr_top`

## Requirements
- R1: The control word at offset 0x34 reads back as {flag, 0, interrupt enable, timer enable, reload[27:0]}: reload count in bits [27:0], timer enable in bit 28, interrupt enable in bit 29 and the expiry flag in bit 31. Bit 30 always reads 0. A control write never changes the flag.
- R2: The counter moves only on clock cycles where `ref_tick` is high. Clock cycles without a tick leave the count untouched.
- R3: With the timer enabled and a non-zero reload count N, the flag is set on the Nth tick after the counter was loaded. The counter then reloads N at once, so the flag comes again every N ticks.
- R4: A control write with bit 28 set loads the counter from the written reload count. A control write with bit 28 clear stops counting, so the flag is never set while the timer is stopped.
- R5: A write to the acknowledge offset 0x38 clears the flag when bit 31 is set. Bit 30 restarts the counter from the stored reload count when the timer is enabled and is ignored when it is stopped. Reading 0x38 returns 0.
- R6: The routing register at 0x24 keeps three bits. Bits [1:0] pick the core and bit 2 picks the fast line (1) or the normal line (0). Higher written bits are dropped and read as 0.
- R7: A request is raised only while both the interrupt enable and the flag are set. It appears on exactly one of the eight output lines, the one named by the routing register.
- R8: After reset the control and routing registers read 0, the timer is stopped and all output lines are low.
- R9: A reload count of zero with the timer enabled keeps the timer idle. It never sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference time base pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_irq | output | 4 | Normal interrupt request per core |
| core_fiq | output | 4 | Fast interrupt request per core |

## Verification
A wrong count state shows up only as a flag that comes early or late, so the bench counts ticks exactly and reads the flag through the control word on the tick before and the tick of the expected expiry. It also leaves many clock cycles between ticks to catch a counter that runs on the clock. A restart that fails to reload is caught on the very next tick, because the bench restarts with one tick left in the period. A routing or gating fault is visible on the output lines in the cycle after the register write, and the bench walks all eight routing codes to catch it.

// File: rtl/ltr_pkg.sv
package ltr_pkg;
    localparam int RELOAD_W = 28;

    localparam logic [7:0] OFS_ROUTE = 8'h24;
    localparam logic [7:0] OFS_CTRL  = 8'h34;
    localparam logic [7:0] OFS_ACK   = 8'h38;

    localparam int TEN_BIT     = 28;
    localparam int IEN_BIT     = 29;
    localparam int RESTART_BIT = 30;
    localparam int FLAG_BIT    = 31;

    typedef struct packed {
        logic                flag;
        logic                ien;
        logic                ten;
        logic [RELOAD_W-1:0] reload;
    } ctrl_t;

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        return {c.flag, 1'b0, c.ien, c.ten, c.reload};
    endfunction
endpackage

// File: rtl/ltr_regs.sv
module ltr_regs
    import ltr_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int ROUTE_W = $clog2(NCORES) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                expire,
    output ctrl_t               ctrl,
    output logic [ROUTE_W-1:0]  route,
    output logic                load,
    output logic [RELOAD_W-1:0] load_val,
    output logic [DATA_W-1:0]   bus_rdata
);
    logic wr_ctrl, wr_ack, wr_route;

    always_comb begin
        wr_ctrl  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_ack   = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_ACK));
        wr_route = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_ROUTE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            route <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.reload <= bus_wdata[RELOAD_W-1:0];
                ctrl.ten    <= bus_wdata[TEN_BIT];
                ctrl.ien    <= bus_wdata[IEN_BIT];
            end
            if (expire)
                ctrl.flag <= 1'b1;
            else if (wr_ack && bus_wdata[FLAG_BIT])
                ctrl.flag <= 1'b0;
            if (wr_route)
                route <= bus_wdata[ROUTE_W-1:0];
        end
    end

    always_comb begin
        load     = 1'b0;
        load_val = ctrl.reload;
        if (wr_ctrl && bus_wdata[TEN_BIT]) begin
            load     = 1'b1;
            load_val = bus_wdata[RELOAD_W-1:0];
        end else if (wr_ack && bus_wdata[RESTART_BIT] && ctrl.ten) begin
            load = 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))
            bus_rdata = DATA_W'(pack_ctrl(ctrl));
        else if (bus_addr == ADDR_W'(OFS_ROUTE))
            bus_rdata = DATA_W'(route);
    end
endmodule

// File: rtl/ltr_counter.sv
module ltr_counter
    import ltr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                ten,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                load,
    input  logic [RELOAD_W-1:0] load_val,
    output logic                expire
);
    logic [RELOAD_W-1:0] cnt;
    logic                step;

    always_comb begin
        step   = tick && ten && (reload != '0);
        expire = step && (cnt <= RELOAD_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (expire)
            cnt <= reload;
        else if (step)
            cnt <= cnt - RELOAD_W'(1);
    end
endmodule

// File: rtl/ltr_router.sv
module ltr_router #(
    parameter int NCORES = 4,
    localparam int SEL_W   = $clog2(NCORES),
    localparam int ROUTE_W = SEL_W + 1
) (
    input  logic               req,
    input  logic [ROUTE_W-1:0] route,
    output logic [NCORES-1:0]  irq,
    output logic [NCORES-1:0]  fiq
);
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic hit;
        assign hit    = req && (route[SEL_W-1:0] == SEL_W'(c));
        assign irq[c] = hit && !route[SEL_W];
        assign fiq[c] = hit &&  route[SEL_W];
    end
endmodule

// File: rtl/ltr_top.sv
module ltr_top
    import ltr_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int ROUTE_W = $clog2(NCORES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCORES-1:0] core_irq,
    output logic [NCORES-1:0] core_fiq
);
    ctrl_t               ctrl;
    logic [ROUTE_W-1:0]  route;
    logic                load;
    logic [RELOAD_W-1:0] load_val;
    logic                expire;
    logic                req;

    ltr_regs #(.NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
        .ctrl(ctrl), .route(route), .load(load), .load_val(load_val),
        .bus_rdata(bus_rdata)
    );

    ltr_counter u_cnt (
        .clk(clk), .rst(rst), .tick(ref_tick), .ten(ctrl.ten),
        .reload(ctrl.reload), .load(load), .load_val(load_val),
        .expire(expire)
    );

    assign req = ctrl.ien && ctrl.flag;

    ltr_router #(.NCORES(NCORES)) u_route (
        .req(req), .route(route), .irq(core_irq), .fiq(core_fiq)
    );
endmodule

// File: rtl/ltr_chk.sv
module ltr_chk
    import ltr_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                ref_tick,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NCORES-1:0]   core_irq,
    input logic [NCORES-1:0]   core_fiq,
    input ctrl_t               ctrl,
    input logic                expire
);
    logic ack_clr;
    assign ack_clr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_ACK))
                     && bus_wdata[FLAG_BIT];

    assert_one_line_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_irq, core_fiq}));

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (|{core_irq, core_fiq}) |-> (ctrl.ien && ctrl.flag));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_clr && !expire) |=> !ctrl.flag);

    assert_expiry_sets_R3: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl.flag);

    assert_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ten |-> !expire);

    assert_zero_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.reload == '0) |-> !expire);

    assert_tick_only_R2: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |-> !expire);
endmodule

bind ltr_top ltr_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .core_irq(core_irq), .core_fiq(core_fiq), .ctrl(ctrl), .expire(expire)
);

// File: tb/tb_ltr_top.sv
module tb_ltr_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_ROUTE = 8'h24;
    localparam logic [7:0] A_CTRL  = 8'h34;
    localparam logic [7:0] A_ACK   = 8'h38;

    // {route code[2:0], expected irq[3:0], expected fiq[3:0]}
    localparam logic [10:0] ROUTE_TAB [8] = '{
        {3'd0, 4'b0001, 4'b0000},
        {3'd1, 4'b0010, 4'b0000},
        {3'd2, 4'b0100, 4'b0000},
        {3'd3, 4'b1000, 4'b0000},
        {3'd4, 4'b0000, 4'b0001},
        {3'd5, 4'b0000, 4'b0010},
        {3'd6, 4'b0000, 4'b0100},
        {3'd7, 4'b0000, 4'b1000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_irq, core_fiq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ltr_top dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_irq(core_irq), .core_fiq(core_fiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic flag_is(input string req, input logic exp);
        logic [31:0] v;
        rd(A_CTRL, v);
        check(req, {31'd0, v[31]}, {31'd0, exp});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        rd(A_CTRL, v);  check("R8 ctrl after reset", v, 32'h0);
        rd(A_ROUTE, v); check("R8 route after reset", v, 32'h0);
        check("R8 lines after reset", {24'd0, core_irq, core_fiq}, 32'h0);

        // R1/R3: period of 3 ticks, interrupt disabled
        wr(A_CTRL, 32'h1000_0003);
        rd(A_CTRL, v); check("R1 ctrl readback", v, 32'h1000_0003);
        ticks(2); flag_is("R3 no flag before 3rd tick", 1'b0);
        ticks(1); flag_is("R3 flag on 3rd tick", 1'b1);
        check("R7 no line while ien clear", {24'd0, core_irq, core_fiq}, 32'h0);

        // R2/R3: idle clocks do not count, period repeats
        wr(A_ACK, 32'h8000_0000);
        repeat (50) @(negedge clk);
        flag_is("R2 no count without tick", 1'b0);
        ticks(2); flag_is("R3 repeat period not early", 1'b0);
        ticks(1); flag_is("R3 repeat period expires", 1'b1);

        // R1/R7: control write keeps flag, request raised
        wr(A_CTRL, 32'h3000_0003);
        flag_is("R1 control write keeps flag", 1'b1);
        check("R7 irq core0", {28'd0, core_irq}, 32'h1);

        // R6/R7: routing table
        for (int i = 0; i < 8; i++) begin
            wr(A_ROUTE, {29'd0, ROUTE_TAB[i][10:8]});
            check("R6 irq lines", {28'd0, core_irq}, {28'd0, ROUTE_TAB[i][7:4]});
            check("R6 fiq lines", {28'd0, core_fiq}, {28'd0, ROUTE_TAB[i][3:0]});
        end
        wr(A_ROUTE, 32'hFFFF_FFFD);
        rd(A_ROUTE, v); check("R6 route keeps 3 bits", v, 32'h5);
        wr(A_ROUTE, 32'h0);

        // R5: acknowledge clears flag, reads zero
        wr(A_ACK, 32'h8000_0000);
        flag_is("R5 ack clears flag", 1'b0);
        check("R7 line drops after ack", {28'd0, core_irq}, 32'h0);
        rd(A_ACK, v); check("R5 ack reads zero", v, 32'h0);

        // R5: restart with one tick left
        ticks(2);
        wr(A_ACK, 32'h4000_0000);
        ticks(1); flag_is("R5 restart reloads count", 1'b0);
        ticks(1); flag_is("R5 restart second tick", 1'b0);
        ticks(1); flag_is("R5 restart period expires", 1'b1);
        wr(A_ACK, 32'h8000_0000);

        // R4: stopped timer, restart ignored
        wr(A_CTRL, 32'h2000_0003);
        wr(A_ACK, 32'h4000_0000);
        ticks(6); flag_is("R4 stopped timer never expires", 1'b0);
        rd(A_CTRL, v); check("R1 ctrl stopped readback", v, 32'h2000_0003);

        // R4: enable loads written value
        wr(A_CTRL, 32'h3000_0005);
        ticks(4); flag_is("R4 load 5 not early", 1'b0);
        ticks(1); flag_is("R4 load 5 expires", 1'b1);
        wr(A_ACK, 32'h8000_0000);

        // R9: zero reload stays idle
        wr(A_CTRL, 32'h3000_0000);
        ticks(8); flag_is("R9 zero reload idle", 1'b0);
        wr(A_ACK, 32'h4000_0000);
        ticks(3); flag_is("R9 zero reload after restart", 1'b0);
        check("R9 no line", {24'd0, core_irq, core_fiq}, 32'h0);

        // R1: bit 30 reads zero, flag not writable
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R1 bit30 zero and flag not written", v, 32'h3FFF_FFFF);

        // R8: reset mid-operation
        wr(A_ROUTE, 32'h7);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(A_CTRL, v);  check("R8 ctrl after second reset", v, 32'h0);
        rd(A_ROUTE, v); check("R8 route after second reset", v, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule